// File: doc/BRIEF.md
# Secure-Launch Command Status Tracker

This block is the status half of a secure-launch command engine in a memory controller hub. It watches single-cycle command strobes that open and close three access windows: a locality-1 window, a locality-2 window and a private window. It also watches per-thread launch-acknowledge and exit-acknowledge cycles. From these inputs it keeps a 24-bit read-only status word. Software polls that word to learn whether a command has taken effect.

Internally the block keeps a mask of the threads that have joined the secure environment. It compares that mask with an existing-thread mask, which firmware or straps drive as an input. The comparison gives two registered flags: launch-done and exit-done. Reading the word has no side effects, so the status word is a plain output.

Top module: `launch_status_tracker`

## Requirements
- R1: While reset is held, the status word is 0x000010. At all times bit 4 reads 1, and every bit other than 16, 15, 7, 4, 1 and 0 reads 0.
- R2: Bit 16 (locality-2 open) sets on the next edge after strobe cmd[2] (open locality-2) or cmd[4] (open private). It clears after strobe cmd[3] (close locality-2) or cmd[5] (close private). With no strobe asserted it holds its value.
- R3: Bit 15 (locality-1 open) sets on the next edge after cmd[0] (open locality-1) and clears after cmd[1] (close locality-1). With neither strobe asserted it holds its value.
- R4: Bit 7 (private open) sets on the next edge after cmd[4] and clears after cmd[5]. With neither strobe asserted it holds its value.
- R5: A launch-acknowledge on thread n sets bit n of the internal joined mask. An exit-acknowledge on thread n clears that bit. If both arrive for the same thread in one cycle, the bit ends up clear.
- R6: Bit 1 (exit-done) is 1 exactly when the joined mask was all zero one cycle earlier. It reads 1 from the first edge after reset is released. It drops after the first launch-acknowledge and returns once every joined thread has exited.
- R7: Bit 0 (launch-done) is 1 exactly when, one cycle earlier, the joined mask equalled a nonzero existing-thread mask. It drops after any exit-acknowledge from a joined thread.
- R8: When a set strobe and a clear strobe for the same window flag arrive in the same cycle, the flag ends up 0.
- R9: The done flags lag the mask update that causes them by one cycle. A poll in the cycle right after the last acknowledge still shows the previous done value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 6 | Command strobes, one cycle each: [0] open loc-1, [1] close loc-1, [2] open loc-2, [3] close loc-2, [4] open private, [5] close private |
| ack_launch | input | NUM_THREADS | One-hot launch-acknowledge, bit n for thread n |
| ack_exit | input | NUM_THREADS | One-hot exit-acknowledge, bit n for thread n |
| thread_exist | input | NUM_THREADS | Mask of existing threads |
| status_word | output | 24 | Read-only status word |

## Verification
The bench builds the block with the default NUM_THREADS of 8. That width is small enough for random one-hot acknowledges to fill the existing mask often, so launch-done is reached many times within a few thousand cycles. It is also wide enough that a mask with holes, such as 0xA5, shows that joins from non-existing threads block the match. Directed sequences use a narrow four-thread existing mask to pin down the one-cycle lag and the exit-wins and clear-wins collisions.

// File: rtl/lst_pkg.sv
// Shared constants and types for the secure-launch status tracker.
// Assumes a fixed 24-bit status word whose bit layout software decodes.
package lst_pkg;
    localparam int STS_W      = 24;
    localparam int CMD_W      = 6;
    // command strobe positions
    localparam int C_OPEN_L1  = 0;
    localparam int C_CLOSE_L1 = 1;
    localparam int C_OPEN_L2  = 2;
    localparam int C_CLOSE_L2 = 3;
    localparam int C_OPEN_PV  = 4;
    localparam int C_CLOSE_PV = 5;
    // status bit positions decoded by software
    localparam int S_L2       = 16;
    localparam int S_L1       = 15;
    localparam int S_PV       = 7;
    localparam int S_FIXED    = 4;
    localparam int S_EXIT     = 1;
    localparam int S_LAUNCH   = 0;

    typedef struct packed {
        logic l2;
        logic l1;
        logic pv;
    } win_flags_t;
endpackage

// File: rtl/lst_win_flags.sv
// Window-open flag registers. Each flag has its own set and clear sources,
// and a clear beats a set in the same cycle. Assumes the strobes are
// single-cycle pulses, already synchronous to clk.
module lst_win_flags
    import lst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] cmd,
    output win_flags_t       flags
);
    win_flags_t nxt;

    // Flag update rule: a clear wins over a set, and no strobe holds the flag.
    function automatic logic upd(input logic cur, input logic set, input logic clr);
        return clr ? 1'b0 : (set ? 1'b1 : cur);
    endfunction

    // Work out the next value of every flag from the strobes.
    always_comb begin
        nxt.l2 = upd(flags.l2, cmd[C_OPEN_L2] | cmd[C_OPEN_PV],
                     cmd[C_CLOSE_L2] | cmd[C_CLOSE_PV]);
        nxt.l1 = upd(flags.l1, cmd[C_OPEN_L1], cmd[C_CLOSE_L1]);
        nxt.pv = upd(flags.pv, cmd[C_OPEN_PV], cmd[C_CLOSE_PV]);
    end

    // Register the flags, with a synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= nxt;
    end
endmodule

// File: rtl/lst_thread_join.sv
// Joined-thread bookkeeping and done-flag derivation. A launch-ack sets a
// thread's joined bit and an exit-ack clears it (exit wins). The done flags
// are registered from the mask one cycle after it updates. Assumes the acks
// are one-hot per cycle, although the logic tolerates any pattern.
module lst_thread_join #(
    parameter int NUM_THREADS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] ack_launch,
    input  logic [NUM_THREADS-1:0] ack_exit,
    input  logic [NUM_THREADS-1:0] thread_exist,
    output logic [NUM_THREADS-1:0] joined,
    output logic                   exit_done,
    output logic                   launch_done
);
    logic [NUM_THREADS-1:0] joined_nxt;

    // Per-thread next joined bit: exit-ack beats launch-ack.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        always_comb joined_nxt[t] = ack_exit[t] ? 1'b0
                                  : (ack_launch[t] ? 1'b1 : joined[t]);
    end

    // Joined-mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) joined <= '0;
        else        joined <= joined_nxt;
    end

    // Done flags, compared from the registered mask (one-cycle lag).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exit_done   <= 1'b0;
            launch_done <= 1'b0;
        end else begin
            exit_done   <= (joined == '0);
            launch_done <= (thread_exist != '0) && (joined == thread_exist);
        end
    end
endmodule

// File: rtl/lst_status_pack.sv
// Assembles the read-only status word from the flags. Bit 4 is tied high
// and all other unused bits are tied low. Purely combinational.
module lst_status_pack
    import lst_pkg::*;
(
    input  win_flags_t       flags,
    input  logic             exit_done,
    input  logic             launch_done,
    output logic [STS_W-1:0] word
);
    // Place every field at its decoded position.
    always_comb begin
        word           = '0;
        word[S_L2]     = flags.l2;
        word[S_L1]     = flags.l1;
        word[S_PV]     = flags.pv;
        word[S_FIXED]  = 1'b1;
        word[S_EXIT]   = exit_done;
        word[S_LAUNCH] = launch_done;
    end
endmodule

// File: rtl/launch_status_tracker.sv
// Top of the secure-launch status tracker. It decodes the window command
// strobes and the per-thread acks, and presents the 24-bit status word.
// Assumes a synchronous active-low reset, and that reading the word has no
// side effects.
module launch_status_tracker
    import lst_pkg::*;
#(
    parameter int NUM_THREADS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CMD_W-1:0]       cmd,
    input  logic [NUM_THREADS-1:0] ack_launch,
    input  logic [NUM_THREADS-1:0] ack_exit,
    input  logic [NUM_THREADS-1:0] thread_exist,
    output logic [STS_W-1:0]       status_word
);
    win_flags_t             flags;
    logic [NUM_THREADS-1:0] joined_mask;
    logic                   exit_done;
    logic                   launch_done;

    lst_win_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .flags (flags)
    );

    lst_thread_join #(.NUM_THREADS(NUM_THREADS)) u_join (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_launch   (ack_launch),
        .ack_exit     (ack_exit),
        .thread_exist (thread_exist),
        .joined       (joined_mask),
        .exit_done    (exit_done),
        .launch_done  (launch_done)
    );

    lst_status_pack u_pack (
        .flags       (flags),
        .exit_done   (exit_done),
        .launch_done (launch_done),
        .word        (status_word)
    );
endmodule

// File: rtl/lst_checker.sv
// Property checker for the status tracker. It is bound into the top module
// and watches the ports and the joined mask between the two submodules.
module lst_checker
    import lst_pkg::*;
#(
    parameter int NUM_THREADS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [CMD_W-1:0]       cmd,
    input logic [NUM_THREADS-1:0] ack_launch,
    input logic [NUM_THREADS-1:0] ack_exit,
    input logic [NUM_THREADS-1:0] thread_exist,
    input logic [NUM_THREADS-1:0] joined,
    input logic [STS_W-1:0]       status_word
);
    localparam logic [STS_W-1:0] LIVE_MASK =
        (STS_W'(1) << S_L2) | (STS_W'(1) << S_L1) | (STS_W'(1) << S_PV) |
        (STS_W'(1) << S_EXIT) | (STS_W'(1) << S_LAUNCH);

    // R1
    fixed_bits_chk: assert property (@(posedge clk)
        (status_word & ~LIVE_MASK) == (STS_W'(1) << S_FIXED));

    // R2
    l2_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd[C_CLOSE_L2] | cmd[C_CLOSE_PV]) |=> !status_word[S_L2]);

    // R2
    l2_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd[C_OPEN_L2] | cmd[C_OPEN_PV]) && !(cmd[C_CLOSE_L2] | cmd[C_CLOSE_PV]))
        |=> status_word[S_L2]);

    // R3
    l1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == '0) |=> $stable(status_word[S_L1]) && $stable(status_word[S_PV])
                        && $stable(status_word[S_L2]));

    // R8
    l1_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd[C_CLOSE_L1] |=> !status_word[S_L1]);

    // R4
    pv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd[C_CLOSE_PV] |=> !status_word[S_PV]);

    // R5
    exit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_launch & ack_exit) != '0) |=> ((joined & $past(ack_launch & ack_exit)) == '0));

    // R6
    exit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (joined == '0) |=> status_word[S_EXIT]);

    // R6
    exit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (joined != '0) |=> !status_word[S_EXIT]);

    // R7
    launch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((thread_exist != '0) && (joined == thread_exist)) |=> status_word[S_LAUNCH]);

    // R7
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (joined != thread_exist) |=> !status_word[S_LAUNCH]);
endmodule

bind launch_status_tracker lst_checker #(.NUM_THREADS(NUM_THREADS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .ack_launch   (ack_launch),
    .ack_exit     (ack_exit),
    .thread_exist (thread_exist),
    .joined       (joined_mask),
    .status_word  (status_word)
);

// File: tb/sim_launch_status_tracker.sv
`timescale 1ns/1ps
// Bench for the status tracker. Random strobes and acks from a fixed seed,
// plus directed corner cases, checked against a model built from the
// requirements.
module sim_launch_status_tracker;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   cmd = '0;
    logic [N-1:0] ack_launch = '0;
    logic [N-1:0] ack_exit = '0;
    logic [N-1:0] thread_exist = '0;
    logic [23:0]  status_word;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model state
    logic         m_l1 = 0, m_l2 = 0, m_pv = 0, m_ed = 0, m_ld = 0;
    logic [N-1:0] m_jn = '0;

    always #2.5 clk = ~clk;

    launch_status_tracker #(.NUM_THREADS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ack_launch(ack_launch),
        .ack_exit(ack_exit), .thread_exist(thread_exist),
        .status_word(status_word)
    );

    // Expected word built from the model flags.
    function automatic logic [23:0] exp_word();
        logic [23:0] w = 24'h000010;
        w[16] = m_l2; w[15] = m_l1; w[7] = m_pv; w[1] = m_ed; w[0] = m_ld;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all();
        logic [23:0] e = exp_word();
        chk("R1 reserved", 32'(status_word & ~24'h018083), 32'(24'h000010));
        chk("R2 loc2", 32'(status_word[16]), 32'(e[16]));
        chk("R3 loc1", 32'(status_word[15]), 32'(e[15]));
        chk("R4 private", 32'(status_word[7]), 32'(e[7]));
        chk("R6 exit-done", 32'(status_word[1]), 32'(e[1]));
        chk("R7 launch-done", 32'(status_word[0]), 32'(e[0]));
    endtask

    // One cycle: drive at negedge, update the model at the edge, check at the next negedge.
    task automatic step(input logic [5:0] c, input logic [N-1:0] la,
                        input logic [N-1:0] le, input logic [N-1:0] ex);
        logic ed_n, ld_n;
        cmd = c; ack_launch = la; ack_exit = le; thread_exist = ex;
        @(posedge clk);
        if (!rst_n) begin
            m_l1 = 0; m_l2 = 0; m_pv = 0; m_ed = 0; m_ld = 0; m_jn = '0;
        end else begin
            ed_n = (m_jn == '0);
            ld_n = (ex != '0) && (m_jn == ex);
            m_jn = (m_jn | la) & ~le;
            m_ed = ed_n; m_ld = ld_n;
            m_l2 = (c[3] | c[5]) ? 1'b0 : ((c[2] | c[4]) ? 1'b1 : m_l2);
            m_l1 = c[1] ? 1'b0 : (c[0] ? 1'b1 : m_l1);
            m_pv = c[5] ? 1'b0 : (c[4] ? 1'b1 : m_pv);
        end
        @(negedge clk);
        chk_all();
    endtask

    task automatic idle(input logic [N-1:0] ex);
        step(6'b0, '0, '0, ex);
    endtask

    initial begin
        logic [N-1:0] ex;
        void'($urandom(32'd20240517));
        @(negedge clk);
        idle('0);
        idle('0);
        chk("R1 reset value", 32'(status_word), 32'h000010);
        rst_n = 1'b1;
        idle(8'h0F);
        chk("R6 exit-done after reset", 32'(status_word[1]), 1);

        // windows: set then clear, and collisions
        step(6'b010101, '0, '0, 8'h0F);
        chk("R2 open-private sets loc2", 32'(status_word[16]), 1);
        chk("R4 open-private sets private", 32'(status_word[7]), 1);
        chk("R3 open loc1", 32'(status_word[15]), 1);
        idle(8'h0F);
        chk("R3 hold", 32'(status_word[15]), 1);
        step(6'b001000, '0, '0, 8'h0F);
        chk("R2 close loc2", 32'(status_word[16]), 0);
        chk("R4 private not closed by loc2 close", 32'(status_word[7]), 1);
        step(6'b000011, '0, '0, 8'h0F);
        chk("R8 loc1 clear wins", 32'(status_word[15]), 0);
        step(6'b110000, '0, '0, 8'h0F);
        chk("R8 private clear wins", 32'(status_word[7]), 0);
        chk("R8 loc2 clear wins", 32'(status_word[16]), 0);

        // launch sequence on threads 0..3
        for (int t = 0; t < 4; t++) step('0, N'(1) << t, '0, 8'h0F);
        chk("R9 launch-done lags", 32'(status_word[0]), 0);
        idle(8'h0F);
        chk("R7 launch-done", 32'(status_word[0]), 1);
        chk("R6 exit-done low while joined", 32'(status_word[1]), 0);
        step('0, '0, 8'h04, 8'h0F);
        chk("R9 launch-done still high", 32'(status_word[0]), 1);
        idle(8'h0F);
        chk("R7 launch-done drops on exit", 32'(status_word[0]), 0);
        // relaunch thread 2 with exit colliding: exit wins
        step('0, 8'h04, 8'h04, 8'h0F);
        idle(8'h0F);
        chk("R5 exit wins collision", 32'(status_word[0]), 0);
        step('0, '0, 8'h01, 8'h0F);
        step('0, '0, 8'h02, 8'h0F);
        step('0, '0, 8'h08, 8'h0F);
        chk("R9 exit-done lags", 32'(status_word[1]), 0);
        idle(8'h0F);
        chk("R6 exit-done returns", 32'(status_word[1]), 1);

        // random phase
        ex = 8'hA5;
        for (int i = 0; i < 4000; i++) begin
            logic [5:0]   c = '0;
            logic [N-1:0] la = '0, le = '0;
            if (i % 500 == 0) ex = (i % 1000 == 0) ? 8'hA5 : N'($urandom);
            if ($urandom % 3 == 0) c = 6'($urandom) & 6'($urandom);
            if ($urandom % 3 == 0) la = N'(1) << ($urandom % N);
            if ($urandom % 5 == 0) le = N'(1) << ($urandom % N);
            step(c, la, le, ex);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #200000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule